// File: doc/BRIEF.md
# Shared Frame Buffer with Access-Conflict Guard

This block holds one radio frame in a small shared memory that two agents use at the same time. A baseband agent fills it while a frame is being received and drains it while a frame is being sent. A host agent does the opposite: it drains received frames and fills frames to be sent. Each side walks the memory with its own address cursor. The block watches how the two cursors move relative to each other and to symbol time. When the host would read a byte that has not arrived yet, or the baseband would send a byte that the host has not yet supplied, the block raises a sticky underrun interrupt flag.

The host can use two access styles. In streaming style its cursor advances by one on every access. In random style every access carries an explicit address. The conflict guard is active only in streaming style. An empty indication tells a streaming reader that it has caught up with the receiver. The reader can then pause instead of causing an underrun. Symbol timing comes from a one-cycle symbol tick. A one-bit modulation select chooses between a slow modulation with long preamble timing and a fast modulation with short preamble timing.

Top module: `fbuf_guard`

## Requirements
- R1: Each port has its own cursor. `bb_rx_start` or `bb_tx_start` sets the baseband cursor to 0, and each baseband read or write cycle uses the cursor and then advances it by one. `host_start` sets the host cursor to 0. Read data appears on `bb_rd_data` or `host_rd_data` one cycle after the read cycle.
- R2: While `mode_sram` is 1, no access pattern sets `irq_ur`.
- R3: While `mode_sram` is 1, a host access uses `host_addr`, and afterwards the host cursor holds `host_addr`+1.
- R4: During receive in streaming style, once at least two octets have been written in earlier cycles, a host read whose cursor equals the baseband cursor sets `irq_ur`.
- R5: During receive, a host read whose cursor equals the baseband cursor does not set `irq_ur` while fewer than two octets have been written.
- R6: During receive in streaming style, a host read sets `irq_ur` if it comes fewer than 8 symbol ticks after `bb_rx_start` (`mod_sel`=0) or fewer than 2 symbol ticks after it (`mod_sel`=1).
- R7: In streaming style, `bb_rx_start` sets `irq_ur` if a host read session is open. A session opens with the first host read and closes with `host_start` or `host_end`.
- R8: After `bb_tx_start` in streaming style, if the host has written no byte since its last `host_start`, `irq_ur` is set on the 41st symbol tick (`mod_sel`=0) or on the 11th symbol tick (`mod_sel`=1), and not before.
- R9: During transmit in streaming style, a baseband read whose cursor equals the host cursor sets `irq_ur`.
- R10: `fb_empty` is 1 exactly when a receive is active and the host cursor equals the baseband cursor.
- R11: `irq_ur` stays set until an `irq_clr` cycle. If a new violation occurs in the same cycle as `irq_clr`, the flag stays set.
- R12: A synchronous reset clears both cursors, `irq_ur`, `fb_empty`, the open session and any pending deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sram | input | 1 | 1 = random host addressing, 0 = streaming |
| mod_sel | input | 1 | 0 = slow modulation timing, 1 = fast modulation timing |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| bb_rx_start | input | 1 | Start of a received frame |
| bb_tx_start | input | 1 | Transmit trigger |
| bb_wr_en | input | 1 | Baseband writes a received octet |
| bb_wr_data | input | DW | Received octet |
| bb_rd_en | input | 1 | Baseband fetches an octet to send |
| bb_rd_data | output | DW | Octet fetched by the baseband |
| host_start | input | 1 | Host begins a new frame access |
| host_end | input | 1 | Host finishes reading a frame |
| host_wr_en | input | 1 | Host writes an octet |
| host_wr_data | input | DW | Host write octet |
| host_rd_en | input | 1 | Host reads an octet |
| host_addr | input | AW | Host address in random style |
| host_rd_data | output | DW | Octet read by the host |
| irq_clr | input | 1 | Host reads the interrupt status and clears the flag |
| irq_ur | output | 1 | Sticky underrun flag |
| fb_empty | output | 1 | Host reader has caught up with the receiver |

## Verification
Most internal errors show up on `irq_ur` or `fb_empty` one clock after the cycle that caused them. Examples are a cursor that skips or sticks, a guard that arms one octet early, or a deadline counter that is off by one tick. A cursor mistake also shows up one clock later as wrong read data, once the affected location is read. A model in the bench tracks the cursors, the timers and the memory independently and compares its results against both flags and both read ports on every clock. This holds through directed corner cases and through a long stretch of mixed random traffic that changes modes and modulation.

// File: rtl/fb_pkg.sv
package fb_pkg;

   typedef enum logic [1:0] {
      LNK_IDLE = 2'd0,
      LNK_RX   = 2'd1,
      LNK_TX   = 2'd2
   } link_e;

   typedef struct packed {
      logic early;
      logic catchup;
      logic overwrite;
      logic late_first;
      logic tx_catchup;
   } viol_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fb_cursor.sv
module fb_cursor #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          step,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= load_val + 1'b1;
      else if (step) cnt <= cnt + 1'b1;
   end

   // R1: a plain step moves the cursor by exactly one
   p_step_r1: assert property (@(posedge clk) disable iff (rst)
      (step && !clr && !load) |=> (cnt == $past(cnt) + 1'b1));

   // R3: a load places the cursor just past the given address
   p_load_r3: assert property (@(posedge clk) disable iff (rst)
      (load && !clr) |=> (cnt == $past(load_val) + 1'b1));

endmodule

// File: rtl/fb_symclk.sv
module fb_symclk #(
   parameter int unsigned SW   = 6,
   parameter int unsigned SMAX = 41
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic          tick,
   output logic [SW-1:0] cnt
);

   localparam logic [SW-1:0] LIM = SW'(SMAX);

   always_ff @(posedge clk) begin
      if (rst)                      cnt <= '0;
      else if (restart)             cnt <= '0;
      else if (tick && cnt != LIM)  cnt <= cnt + 1'b1;
   end

   // R8: the symbol count never passes its saturation point
   p_sym_bound_r8: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);

endmodule

// File: rtl/fb_store.sv
module fb_store #(
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned DW     = 8,
   parameter int unsigned AW     = 7,
   parameter bit          REG_RD = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          a_we,
   input  logic [AW-1:0] a_waddr,
   input  logic [DW-1:0] a_wdata,
   input  logic          b_we,
   input  logic [AW-1:0] b_waddr,
   input  logic [DW-1:0] b_wdata,
   input  logic          a_re,
   input  logic [AW-1:0] a_raddr,
   output logic [DW-1:0] a_rdata,
   input  logic          b_re,
   input  logic [AW-1:0] b_raddr,
   output logic [DW-1:0] b_rdata
);

   logic [DW-1:0] mem [DEPTH];

   // port a (baseband) is written last, so it wins a same-address collision
   always_ff @(posedge clk) begin
      if (b_we) mem[b_waddr] <= b_wdata;
      if (a_we) mem[a_waddr] <= a_wdata;
   end

   generate
      if (REG_RD) begin : g_reg_rd
         always_ff @(posedge clk) begin
            if (rst) begin
               a_rdata <= '0;
               b_rdata <= '0;
            end else begin
               if (a_re) a_rdata <= mem[a_raddr];
               if (b_re) b_rdata <= mem[b_raddr];
            end
         end
      end else begin : g_comb_rd
         logic unused_rd;
         assign unused_rd = rst ^ a_re ^ b_re;
         assign a_rdata   = mem[a_raddr];
         assign b_rdata   = mem[b_raddr];
      end
   endgenerate

endmodule

// File: rtl/fb_guard.sv
module fb_guard
   import fb_pkg::*;
#(
   parameter int unsigned AW       = 7,
   parameter int unsigned SW       = 6,
   parameter int unsigned BP_SHR   = 41,
   parameter int unsigned OQ_SHR   = 11,
   parameter int unsigned BP_RD    = 8,
   parameter int unsigned OQ_RD    = 2,
   parameter int unsigned RX_GUARD = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          streaming,
   input  logic          mod_sel,
   input  logic          sym_tick,
   input  logic [SW-1:0] sym_cnt,
   input  logic          rx_start,
   input  logic          tx_start,
   input  logic          rx_live,
   input  logic          tx_live,
   input  logic          host_start,
   input  logic          host_end,
   input  logic          host_rd,
   input  logic          host_wr,
   input  logic          bb_wr,
   input  logic          bb_rd,
   input  logic [AW-1:0] hcnt,
   input  logic [AW-1:0] bcnt,
   input  logic          irq_clr,
   output logic          irq_ur
);

   localparam logic [SW-1:0] BP_RD_V  = SW'(BP_RD);
   localparam logic [SW-1:0] OQ_RD_V  = SW'(OQ_RD);
   localparam logic [SW-1:0] BP_LAST  = SW'(BP_SHR - 1);
   localparam logic [SW-1:0] OQ_LAST  = SW'(OQ_SHR - 1);
   localparam logic [AW-1:0] ARM_AT   = AW'(RX_GUARD - 1);

   logic          armed_q, sess_q, hwr_q, pend_q;
   logic          fire, any_viol;
   logic [SW-1:0] rd_dly, shr_last;
   viol_t         v;

   always_comb begin
      rd_dly       = mod_sel ? OQ_RD_V : BP_RD_V;
      shr_last     = mod_sel ? OQ_LAST : BP_LAST;
      fire         = pend_q && sym_tick && (sym_cnt == shr_last);
      v.early      = streaming && host_rd && rx_live && (sym_cnt < rd_dly);
      v.catchup    = streaming && host_rd && rx_live && armed_q && (hcnt == bcnt);
      v.overwrite  = streaming && rx_start && sess_q;
      v.late_first = streaming && fire && !hwr_q;
      v.tx_catchup = streaming && bb_rd && tx_live && (bcnt == hcnt);
      any_viol     = |v;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_ur  <= 1'b0;
         armed_q <= 1'b0;
         sess_q  <= 1'b0;
         hwr_q   <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (any_viol)     irq_ur <= 1'b1;
         else if (irq_clr) irq_ur <= 1'b0;

         if (rx_start)                                 armed_q <= 1'b0;
         else if (bb_wr && rx_live && bcnt >= ARM_AT)  armed_q <= 1'b1;

         if (host_start || host_end)   sess_q <= 1'b0;
         else if (streaming && host_rd) sess_q <= 1'b1;

         if (host_start)   hwr_q <= 1'b0;
         else if (host_wr) hwr_q <= 1'b1;

         if (rx_start)      pend_q <= 1'b0;
         else if (tx_start) pend_q <= 1'b1;
         else if (fire)     pend_q <= 1'b0;
      end
   end

   // R2: random-address style never raises the flag
   p_sram_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (!streaming && !irq_ur) |=> !irq_ur);

   // R11: the flag holds until a clear
   p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      (irq_ur && !irq_clr) |=> irq_ur);

   // R7: a new frame arriving under an open read session raises the flag
   p_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
      (streaming && rx_start && sess_q) |=> irq_ur);

   // R8: a missed first-byte deadline raises the flag
   p_deadline_r8: assert property (@(posedge clk) disable iff (rst)
      (streaming && fire && !hwr_q) |=> irq_ur);

   // R6: a read before the settle delay raises the flag
   p_early_r6: assert property (@(posedge clk) disable iff (rst)
      (streaming && host_rd && rx_live && sym_cnt < rd_dly) |=> irq_ur);

endmodule

// File: rtl/fbuf_guard.sv
module fbuf_guard
   import fb_pkg::*;
#(
   parameter int unsigned DEPTH    = 128,
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = $clog2(DEPTH),
   parameter int unsigned BP_SHR   = 41,
   parameter int unsigned OQ_SHR   = 11,
   parameter int unsigned BP_RD    = 8,
   parameter int unsigned OQ_RD    = 2,
   parameter int unsigned RX_GUARD = 2,
   parameter bit          REG_RD   = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mode_sram,
   input  logic          mod_sel,
   input  logic          sym_tick,
   input  logic          bb_rx_start,
   input  logic          bb_tx_start,
   input  logic          bb_wr_en,
   input  logic [DW-1:0] bb_wr_data,
   input  logic          bb_rd_en,
   output logic [DW-1:0] bb_rd_data,
   input  logic          host_start,
   input  logic          host_end,
   input  logic          host_wr_en,
   input  logic [DW-1:0] host_wr_data,
   input  logic          host_rd_en,
   input  logic [AW-1:0] host_addr,
   output logic [DW-1:0] host_rd_data,
   input  logic          irq_clr,
   output logic          irq_ur,
   output logic          fb_empty
);

   localparam int unsigned SMAX = max2(max2(BP_SHR, OQ_SHR), max2(BP_RD, OQ_RD));
   localparam int unsigned SW   = $clog2(SMAX + 1);

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fbuf_guard: DEPTH must be a power of two >= 4 matching AW");
      end
      if (BP_SHR < 2 || OQ_SHR < 2) begin : g_bad_shr
         $error("fbuf_guard: header deadlines must be at least 2 symbols");
      end
      if (RX_GUARD < 1 || RX_GUARD > DEPTH) begin : g_bad_guard
         $error("fbuf_guard: RX_GUARD out of range");
      end
   endgenerate

   link_e         link_q;
   logic          streaming, rx_live, tx_live, host_acc;
   logic [AW-1:0] hcnt, bcnt, haddr;
   logic [SW-1:0] sym_cnt;

   assign streaming = !mode_sram;
   assign rx_live   = (link_q == LNK_RX);
   assign tx_live   = (link_q == LNK_TX);
   assign host_acc  = host_rd_en || host_wr_en;
   assign haddr     = mode_sram ? host_addr : hcnt;
   assign fb_empty  = rx_live && (hcnt == bcnt);

   always_ff @(posedge clk) begin
      if (rst)              link_q <= LNK_IDLE;
      else if (bb_rx_start) link_q <= LNK_RX;
      else if (bb_tx_start) link_q <= LNK_TX;
   end

   fb_cursor #(.AW(AW)) u_bcur (
      .clk(clk), .rst(rst),
      .clr(bb_rx_start || bb_tx_start),
      .step(bb_wr_en || bb_rd_en),
      .load(1'b0), .load_val('0),
      .cnt(bcnt)
   );

   fb_cursor #(.AW(AW)) u_hcur (
      .clk(clk), .rst(rst),
      .clr(host_start),
      .step(host_acc && streaming),
      .load(host_acc && mode_sram),
      .load_val(host_addr),
      .cnt(hcnt)
   );

   fb_symclk #(.SW(SW), .SMAX(SMAX)) u_sym (
      .clk(clk), .rst(rst),
      .restart(bb_rx_start || bb_tx_start),
      .tick(sym_tick),
      .cnt(sym_cnt)
   );

   fb_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .REG_RD(REG_RD)) u_mem (
      .clk(clk), .rst(rst),
      .a_we(bb_wr_en),   .a_waddr(bcnt),  .a_wdata(bb_wr_data),
      .b_we(host_wr_en), .b_waddr(haddr), .b_wdata(host_wr_data),
      .a_re(bb_rd_en),   .a_raddr(bcnt),  .a_rdata(bb_rd_data),
      .b_re(host_rd_en), .b_raddr(haddr), .b_rdata(host_rd_data)
   );

   fb_guard #(
      .AW(AW), .SW(SW), .BP_SHR(BP_SHR), .OQ_SHR(OQ_SHR),
      .BP_RD(BP_RD), .OQ_RD(OQ_RD), .RX_GUARD(RX_GUARD)
   ) u_guard (
      .clk(clk), .rst(rst),
      .streaming(streaming), .mod_sel(mod_sel),
      .sym_tick(sym_tick), .sym_cnt(sym_cnt),
      .rx_start(bb_rx_start), .tx_start(bb_tx_start),
      .rx_live(rx_live), .tx_live(tx_live),
      .host_start(host_start), .host_end(host_end),
      .host_rd(host_rd_en), .host_wr(host_wr_en),
      .bb_wr(bb_wr_en), .bb_rd(bb_rd_en),
      .hcnt(hcnt), .bcnt(bcnt),
      .irq_clr(irq_clr), .irq_ur(irq_ur)
   );

   // R10: the empty indication only appears while receiving
   p_empty_rx_r10: assert property (@(posedge clk) disable iff (rst)
      bb_tx_start |=> !fb_empty);

endmodule

// File: tb/sim_fbuf_guard.sv
`timescale 1ns/1ps
module sim_fbuf_guard;

   logic       clk = 1'b0;
   logic       rst;
   logic       mode_sram, mod_sel, sym_tick;
   logic       bb_rx_start, bb_tx_start, bb_wr_en, bb_rd_en;
   logic [7:0] bb_wr_data, bb_rd_data;
   logic       host_start, host_end, host_wr_en, host_rd_en, irq_clr;
   logic [7:0] host_wr_data, host_rd_data;
   logic [6:0] host_addr;
   logic       irq_ur, fb_empty;

   always #2 clk = ~clk;

   fbuf_guard u0 (
      .clk(clk), .rst(rst), .mode_sram(mode_sram), .mod_sel(mod_sel),
      .sym_tick(sym_tick), .bb_rx_start(bb_rx_start), .bb_tx_start(bb_tx_start),
      .bb_wr_en(bb_wr_en), .bb_wr_data(bb_wr_data), .bb_rd_en(bb_rd_en),
      .bb_rd_data(bb_rd_data), .host_start(host_start), .host_end(host_end),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
      .host_addr(host_addr), .host_rd_data(host_rd_data), .irq_clr(irq_clr),
      .irq_ur(irq_ur), .fb_empty(fb_empty)
   );

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    done   = 0;
   string cur_req = "R12";

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_mem [128];
   bit         m_ok  [128];
   int  m_h, m_b, m_sym;
   bit  m_irq, m_rx, m_tx, m_arm, m_sess, m_hw, m_pend;
   logic [7:0] m_hrd, m_brd;
   bit  m_hv, m_bv;

   initial for (int i = 0; i < 128; i++) m_ok[i] = 0;

   always @(posedge clk) begin
      int  haddr, rddly, shr;
      bit  stream, v, fire;
      if (rst) begin
         m_h = 0; m_b = 0; m_sym = 0; m_irq = 0; m_rx = 0; m_tx = 0;
         m_arm = 0; m_sess = 0; m_hw = 0; m_pend = 0; m_hv = 0; m_bv = 0;
      end else begin
         stream = !mode_sram;
         haddr  = mode_sram ? int'(host_addr) : m_h;
         rddly  = mod_sel ? 2 : 8;
         shr    = mod_sel ? 11 : 41;
         fire   = m_pend && sym_tick && (m_sym == shr - 1);
         v = 0;
         if (stream && host_rd_en && m_rx && (m_sym < rddly || (m_arm && m_h == m_b))) v = 1;
         if (stream && bb_rx_start && m_sess) v = 1;
         if (stream && bb_rd_en && m_tx && m_b == m_h) v = 1;
         if (stream && fire && !m_hw) v = 1;
         if (host_rd_en) begin m_hrd = m_mem[haddr]; m_hv = m_ok[haddr]; end
         if (bb_rd_en)   begin m_brd = m_mem[m_b];   m_bv = m_ok[m_b];   end
         if (host_wr_en) begin m_mem[haddr] = host_wr_data; m_ok[haddr] = 1; end
         if (bb_wr_en)   begin m_mem[m_b] = bb_wr_data;     m_ok[m_b] = 1;   end
         if (v) m_irq = 1; else if (irq_clr) m_irq = 0;
         if (bb_rx_start) m_arm = 0;
         else if (bb_wr_en && m_rx && m_b >= 1) m_arm = 1;
         if (host_start || host_end) m_sess = 0;
         else if (stream && host_rd_en) m_sess = 1;
         if (host_start) m_hw = 0; else if (host_wr_en) m_hw = 1;
         if (bb_rx_start) m_pend = 0;
         else if (bb_tx_start) m_pend = 1;
         else if (fire) m_pend = 0;
         if (bb_rx_start || bb_tx_start) m_sym = 0;
         else if (sym_tick && m_sym < 41) m_sym = m_sym + 1;
         if (bb_rx_start) begin m_rx = 1; m_tx = 0; end
         else if (bb_tx_start) begin m_rx = 0; m_tx = 1; end
         if (bb_rx_start || bb_tx_start) m_b = 0;
         else if (bb_wr_en || bb_rd_en) m_b = (m_b + 1) % 128;
         if (host_start) m_h = 0;
         else if (host_wr_en || host_rd_en) m_h = (haddr + 1) % 128;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // every clock: compare all outputs against the model
   always @(negedge clk) begin
      if (cyc > 0) begin
         chk(irq_ur === m_irq, cur_req, "irq_ur", int'(irq_ur), int'(m_irq));
         chk(fb_empty === (m_rx && m_h == m_b), "R10", "fb_empty",
             int'(fb_empty), int'(m_rx && m_h == m_b));
         if (m_hv) chk(host_rd_data === m_hrd, "R1", "host_rd_data",
                       int'(host_rd_data), int'(m_hrd));
         if (m_bv) chk(bb_rd_data === m_brd, "R1", "bb_rd_data",
                       int'(bb_rd_data), int'(m_brd));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !done) begin
         fails++; checks++;
         $display("FAIL R12 watchdog: got %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic go();
      @(negedge clk);
      sym_tick = 0; bb_rx_start = 0; bb_tx_start = 0; bb_wr_en = 0; bb_rd_en = 0;
      host_start = 0; host_end = 0; host_wr_en = 0; host_rd_en = 0; irq_clr = 0;
   endtask

   task automatic syms(input int n);
      for (int i = 0; i < n; i++) begin sym_tick = 1; go(); end
   endtask

   task automatic expect1(input logic act, input logic exp, input string req, input string what);
      chk(act === exp, req, what, int'(act), int'(exp));
   endtask

   initial begin
      rst = 1; mode_sram = 0; mod_sel = 0; host_addr = '0;
      bb_wr_data = '0; host_wr_data = '0;
      sym_tick = 0; bb_rx_start = 0; bb_tx_start = 0; bb_wr_en = 0; bb_rd_en = 0;
      host_start = 0; host_end = 0; host_wr_en = 0; host_rd_en = 0; irq_clr = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      go();
      expect1(irq_ur, 1'b0, "R12", "irq after reset");
      expect1(fb_empty, 1'b0, "R12", "empty after reset");

      // R6: early read in slow modulation
      cur_req = "R6";
      bb_rx_start = 1; go(); syms(3);
      host_rd_en = 1; go();
      expect1(irq_ur, 1'b1, "R6", "early read");
      cur_req = "R11";
      irq_clr = 1; go();
      expect1(irq_ur, 1'b0, "R11", "clear");

      // R1 / R10 / R5
      cur_req = "R1";
      syms(5);
      host_start = 1; go();
      bb_wr_en = 1; bb_wr_data = 8'hA5; go();
      host_rd_en = 1; go(); go();
      expect1(host_rd_data == 8'hA5, 1'b1, "R1", "rx data");
      expect1(irq_ur, 1'b0, "R6", "read after delay");
      expect1(fb_empty, 1'b1, "R10", "caught up");
      cur_req = "R5";
      host_rd_en = 1; go();
      expect1(irq_ur, 1'b0, "R5", "unarmed catch-up");
      for (int i = 0; i < 3; i++) begin
         bb_wr_en = 1; bb_wr_data = 8'(i + 1); go();
      end
      cur_req = "R4";
      host_rd_en = 1; go();
      host_rd_en = 1; go();
      expect1(fb_empty, 1'b1, "R10", "caught up again");
      host_rd_en = 1; go();
      expect1(irq_ur, 1'b1, "R4", "armed catch-up");
      irq_clr = 1; go();

      // R7: new frame over open session
      cur_req = "R7";
      bb_rx_start = 1; go();
      expect1(irq_ur, 1'b1, "R7", "overwrite");
      irq_clr = 1; go();
      host_end = 1; go();
      bb_rx_start = 1; go();
      expect1(irq_ur, 1'b0, "R7", "closed session");

      // R11: set wins over clear
      cur_req = "R11";
      host_rd_en = 1; irq_clr = 1; go();
      expect1(irq_ur, 1'b1, "R11", "set beats clear");
      irq_clr = 1; go();

      // R2 / R3 random style
      cur_req = "R2";
      mode_sram = 1;
      bb_rx_start = 1; go();
      host_rd_en = 1; host_addr = 7'd0; go();
      expect1(irq_ur, 1'b0, "R2", "early read ignored");
      bb_wr_en = 1; bb_wr_data = 8'h11; go();
      bb_wr_en = 1; bb_wr_data = 8'h22; go();
      bb_wr_en = 1; bb_wr_data = 8'h33; go();
      cur_req = "R3";
      host_rd_en = 1; host_addr = 7'd2; go(); go();
      expect1(host_rd_data == 8'h33, 1'b1, "R3", "addressed read");
      expect1(fb_empty, 1'b1, "R3", "cursor at addr+1");
      host_rd_en = 1; host_addr = 7'd3; go();
      expect1(irq_ur, 1'b0, "R2", "catch-up ignored");
      mode_sram = 0;

      // transmit path
      cur_req = "R8";
      host_start = 1; go();
      host_wr_en = 1; host_wr_data = 8'hC1; go();
      host_wr_en = 1; host_wr_data = 8'hC2; go();
      host_wr_en = 1; host_wr_data = 8'hC3; go();
      bb_tx_start = 1; go(); syms(41);
      expect1(irq_ur, 1'b0, "R8", "first byte present");
      bb_rd_en = 1; go(); go();
      expect1(bb_rd_data == 8'hC1, 1'b1, "R1", "tx data");
      bb_rd_en = 1; go(); bb_rd_en = 1; go(); go();
      expect1(bb_rd_data == 8'hC3, 1'b1, "R1", "tx data last");
      cur_req = "R9";
      bb_rd_en = 1; go();
      expect1(irq_ur, 1'b1, "R9", "tx catch-up");
      irq_clr = 1; go();

      cur_req = "R8";
      host_start = 1; go();
      bb_tx_start = 1; go(); syms(40);
      expect1(irq_ur, 1'b0, "R8", "slow deadline not yet");
      syms(1);
      expect1(irq_ur, 1'b1, "R8", "slow deadline");
      irq_clr = 1; go();
      mod_sel = 1;
      bb_tx_start = 1; go(); syms(10);
      expect1(irq_ur, 1'b0, "R8", "fast deadline not yet");
      syms(1);
      expect1(irq_ur, 1'b1, "R8", "fast deadline");
      irq_clr = 1; go();

      cur_req = "R6";
      bb_rx_start = 1; go(); syms(1);
      host_start = 1; go();
      host_rd_en = 1; go();
      expect1(irq_ur, 1'b1, "R6", "fast early read");
      irq_clr = 1; go(); host_end = 1; go();
      syms(1);
      host_start = 1; go();
      host_rd_en = 1; go();
      expect1(irq_ur, 1'b0, "R6", "fast read after delay");

      // mixed random traffic, model compared every clock
      cur_req = "R4";
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(199) == 0) mode_sram = ~mode_sram;
         if ($urandom_range(299) == 0) mod_sel = ~mod_sel;
         sym_tick     = ($urandom_range(3) == 0);
         bb_rx_start  = ($urandom_range(79) == 0);
         bb_tx_start  = ($urandom_range(79) == 0);
         host_start   = ($urandom_range(49) == 0);
         host_end     = ($urandom_range(49) == 0);
         bb_wr_en     = ($urandom_range(2) == 0);
         bb_rd_en     = ($urandom_range(3) == 0);
         host_wr_en   = ($urandom_range(3) == 0);
         host_rd_en   = ($urandom_range(2) == 0);
         irq_clr      = ($urandom_range(7) == 0);
         host_addr    = 7'($urandom_range(127));
         bb_wr_data   = 8'($urandom_range(255));
         host_wr_data = 8'($urandom_range(255));
         go();
      end

      // R12: reset in mid-traffic
      cur_req = "R12";
      bb_rx_start = 1; go(); host_rd_en = 1; go();
      rst = 1; go(); rst = 0; go();
      expect1(irq_ur, 1'b0, "R12", "irq after late reset");
      expect1(fb_empty, 1'b0, "R12", "empty after late reset");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule